// File: doc/BRIEF.md
# Stereo Serial Audio DAC Transmitter

This block feeds a 16-bit stereo serial audio DAC from one fast system clock. It divides the system clock down to a bit clock and a channel-select frame sync, and both run freely from the moment reset is released. Each frame of 32 bit-clock periods carries one left and one right sample, most significant bit first, in two's complement. The left sample goes out while the frame sync is high and the right sample while it is low.

The start of every frame is found by a double-register edge detector on the frame sync. The pulse from that detector is the one-cycle ready strobe of a valid/ready sample port. A left/right pair offered with valid in that cycle is taken as a unit and shifted out in the same frame. If no pair is offered, the previous pair is sent again, so the serial stream never stalls. Serial data only changes while the bit clock is low, which keeps it steady at the DAC's rising-edge sample point.

Top module: `stereo_dac_tx`

## Requirements
- R1: The bit clock has a period of DIV system clocks (DIV even, at least 6, default 8) with DIV/2 cycles high and DIV/2 low. It starts low for DIV/2 cycles once the internal reset releases, which happens two system clocks after rst_n rises.
- R2: The frame sync changes only on falling bit-clock edges. It is high for 16 bit-clock periods and then low for 16, and its first rise comes at the first falling bit-clock edge after reset.
- R3: Slot s of a frame (s = 0..31, counted from the frame-sync rise) is sampled at the rising bit-clock edge inside that slot. It carries bit 15-s of the left sample for s < 16 and bit 31-s of the right sample for s >= 16, so each channel goes out MSB first.
- R4: Serial data is stable for as long as the bit clock is high.
- R5: Ready is high for exactly one system clock per frame. That cycle begins one system clock after the edge where the frame sync rises, so ready is only ever high while the frame sync is high and the bit clock is low.
- R6: A left/right pair presented with valid high during the ready cycle is shifted out, both channels, in that same frame.
- R7: When valid is low during the ready cycle, the frame repeats the most recently accepted pair.
- R8: Valid and sample data outside the ready cycle have no effect on the serial output.
- R9: While reset is active, bit clock, frame sync, serial data and ready are all low. After reset, the held pair is zero until a pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | One-cycle frame-start strobe; a pair is taken when valid is also high |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| dac_bclk | output | 1 | Bit clock to the DAC |
| dac_fsync | output | 1 | Channel-select frame sync (high = left) |
| dac_sdata | output | 1 | Serial sample data |

## Verification
Some properties are checked on every cycle. These are the high and low lengths of the bit clock, the frame sync moving only on falling bit-clock edges, serial data holding still while the bit clock is high, ready being a single-cycle pulse inside a left half-frame, and all outputs being quiet during reset. Other behaviours need the bench's scenarios and its reference model. These are the actual bit order across a frame, the pairing of left and right from one transfer, the repetition of the last pair when no sample is offered, the fact that data offered outside the ready cycle is ignored, and the zeroed hold after a mid-run reset.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;

  // operation applied to the output shift register in a given cycle
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LOAD  = 2'd2
  } sh_op_e;

endpackage

// File: rtl/sdtx_clkgen.sv
module sdtx_clkgen #(
  parameter int unsigned DIV      = 8,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic fsync,
  output logic fall_tick
);

  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned PH_W  = $clog2(DIV);
  localparam int unsigned SLOTS = 2 * SAMPLE_W;
  localparam int unsigned SL_W  = $clog2(SLOTS);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE  = PH_W'(HALF - 1);
  localparam logic [SL_W-1:0] SL_LAST  = SL_W'(SLOTS - 1);
  localparam logic [SL_W-1:0] SL_RIGHT = SL_W'(SAMPLE_W);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [SL_W-1:0] slot_q, slot_d;
  logic            bclk_q, bclk_d;
  logic            fs_q, fs_d;
  logic            ph_last, rise_pt, slot_en;

  // next state
  always_comb begin
    ph_last = (ph_q == PH_LAST);
    rise_pt = (ph_q == PH_RISE);
    slot_en = ph_last;
    ph_d    = ph_last ? '0 : ph_q + 1'b1;
    if (rise_pt)      bclk_d = 1'b1;
    else if (ph_last) bclk_d = 1'b0;
    else              bclk_d = bclk_q;
    slot_d  = (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;
    fs_d    = (slot_d < SL_RIGHT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bclk_q <= 1'b0;
      slot_q <= SL_LAST;
      fs_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bclk_q <= bclk_d;
      if (slot_en) begin
        slot_q <= slot_d;
        fs_q   <= fs_d;
      end
    end
  end

  assign bclk      = bclk_q;
  assign fsync     = fs_q;
  assign fall_tick = ph_last;

endmodule

// File: rtl/sdtx_fsync_edge.sv
module sdtx_fsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic frame_start
);

  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= fsync;
      stage2_q <= stage1_q;
    end
  end

  assign frame_start = stage1_q & ~stage2_q;

endmodule

// File: rtl/sdtx_sample_hold.sv
module sdtx_sample_hold #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  in_valid,
  input  logic [SAMPLE_W-1:0]   in_left,
  input  logic [SAMPLE_W-1:0]   in_right,
  output logic                  in_ready,
  output logic [2*SAMPLE_W-1:0] pair_out
);

  logic [2*SAMPLE_W-1:0] hold_q, hold_d;
  logic                  take;

  always_comb begin
    take     = frame_start & in_valid;
    hold_d   = {in_left, in_right};
    pair_out = take ? hold_d : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (take) begin
      hold_q <= hold_d;
    end
  end

  assign in_ready = frame_start;

endmodule

// File: rtl/sdtx_shifter.sv
module sdtx_shifter
  import sdtx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  shift,
  input  logic [2*SAMPLE_W-1:0] pair_in,
  output logic                  sdata
);

  localparam int unsigned SR_W = 2 * SAMPLE_W;

  logic [SR_W-1:0] sr_q, sr_d;
  sh_op_e          op;

  always_comb begin
    if (load)       op = SH_LOAD;
    else if (shift) op = SH_SHIFT;
    else            op = SH_HOLD;
    case (op)
      SH_LOAD:  sr_d = pair_in;
      SH_SHIFT: sr_d = {sr_q[SR_W-2:0], 1'b0};
      default:  sr_d = sr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (op != SH_HOLD) begin
      sr_q <= sr_d;
    end
  end

  assign sdata = sr_q[SR_W-1];

endmodule

// File: rtl/stereo_dac_tx.sv
module stereo_dac_tx #(
  parameter int unsigned DIV      = 8,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                dac_bclk,
  output logic                dac_fsync,
  output logic                dac_sdata
);

  logic                  rst_meta_n, rst_sync_n;
  logic                  fall_tick, frame_start;
  logic [2*SAMPLE_W-1:0] pair;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sdtx_clkgen #(.DIV(DIV), .SAMPLE_W(SAMPLE_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bclk      (dac_bclk),
    .fsync     (dac_fsync),
    .fall_tick (fall_tick)
  );

  sdtx_fsync_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fsync       (dac_fsync),
    .frame_start (frame_start)
  );

  sdtx_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .in_valid    (smp_valid),
    .in_left     (smp_left),
    .in_right    (smp_right),
    .in_ready    (smp_ready),
    .pair_out    (pair)
  );

  sdtx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (frame_start),
    .shift   (fall_tick),
    .pair_in (pair),
    .sdata   (dac_sdata)
  );

endmodule

// File: rtl/sdtx_chk.sv
module sdtx_chk #(
  parameter int unsigned DIV = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic sdata,
  input logic ready
);

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV) + 1;

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= bclk ? hi_cnt + 1'b1 : '0;
      lo_cnt <= bclk ? '0 : lo_cnt + 1'b1;
    end
  end

  // R1
  bclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk |-> (hi_cnt < CW'(HALF)));

  // R1
  bclk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk |-> (lo_cnt < CW'(HALF)));

  // R2
  fsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $fell(bclk));

  // R4
  sdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && $past(bclk)) |-> $stable(sdata));

  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R5
  ready_in_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (fsync && !bclk));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!bclk && !fsync && !sdata && !ready);
    end
  end

endmodule

bind stereo_dac_tx sdtx_chk #(.DIV(DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .bclk  (dac_bclk),
  .fsync (dac_fsync),
  .sdata (dac_sdata),
  .ready (smp_ready)
);

// File: tb/stereo_dac_tx_test.sv
module stereo_dac_tx_test;

  localparam int DIV    = 8;
  localparam int W      = 16;
  localparam int HALF   = DIV / 2;
  localparam int FRAMEK = 2 * W * DIV;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_valid;
  logic         smp_ready;
  logic [W-1:0] smp_left, smp_right;
  logic         dac_bclk, dac_fsync, dac_sdata;

  int           kraw;
  int           phase;
  int           n_cmp, n_bad;
  bit           done;
  logic [W-1:0] cur_l, cur_r;

  always #5 clk = ~clk;

  stereo_dac_tx #(.DIV(DIV), .SAMPLE_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .dac_bclk  (dac_bclk),
    .dac_fsync (dac_fsync),
    .dac_sdata (dac_sdata)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) kraw <= kraw + 1;

  // reference model, compared every cycle
  always @(negedge clk) begin
    int    k, ph, slot, fr;
    logic  e_bclk, e_fs, e_rdy, e_bit, v;
    logic [W-1:0] nl, nr;
    string cat;
    k = kraw - 2;
    if (!rst_n || k <= 0) begin
      // R9 quiet outputs while reset is active or still synchronising
      chk("R9", dac_bclk, 1'b0);
      chk("R9", dac_fsync, 1'b0);
      chk("R9", dac_sdata, 1'b0);
      chk("R9", smp_ready, 1'b0);
      smp_valid = 1'b0;
    end else begin
      ph     = k % DIV;
      slot   = ((k / DIV) + 2 * W - 1) % (2 * W);
      fr     = k / FRAMEK;
      e_bclk = (ph >= HALF);
      e_fs   = (slot < W);
      e_rdy  = ((k % FRAMEK) == DIV + 1);
      chk("R1", dac_bclk, e_bclk);
      chk("R2", dac_fsync, e_fs);
      chk("R5", smp_ready, e_rdy);
      // stimulus for the next cycle, chosen per frame
      nl = W'($urandom);
      nr = W'($urandom);
      if (phase == 0) begin
        if (fr < 6)       begin cat = "R6"; v = 1'b1; end
        else if (fr < 10) begin cat = "R7"; v = 1'b0; end
        else if (fr < 14) begin cat = "R8"; v = !e_rdy; end
        else if (fr < 18) begin
          cat = "R3"; v = e_rdy;
          case (fr - 14)
            0:       begin nl = 16'h8000; nr = 16'h7FFF; end
            1:       begin nl = 16'hFFFF; nr = 16'h0000; end
            2:       begin nl = 16'hA5A5; nr = 16'h5A5A; end
            default: begin nl = 16'h0001; nr = 16'h8000; end
          endcase
        end
        else begin cat = "R6"; v = 1'b1; end
      end else begin
        if (fr == 0)      begin cat = "R9"; v = 1'b0; end
        else if (fr == 1) begin cat = "R6"; v = 1'b1; end
        else              begin cat = "R7"; v = 1'b0; end
      end
      if (e_rdy && v) begin
        cur_l = nl;
        cur_r = nr;
      end
      if (e_bclk) begin
        e_bit = (slot < W) ? cur_l[W-1-slot] : cur_r[2*W-1-slot];
        if (ph == HALF) chk(cat, dac_sdata, e_bit);
        else            chk("R4", dac_sdata, e_bit);
      end
      smp_valid = v;
      smp_left  = nl;
      smp_right = nr;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    kraw = 0; phase = 0;
    cur_l = '0; cur_r = '0;
    smp_valid = 1'b0; smp_left = '0; smp_right = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    wait (kraw >= 22 * FRAMEK + 2);
    // mid-run reset: hold must return to zero
    @(posedge clk);
    #2 rst_n = 1'b0;
    kraw = 0; phase = 1;
    cur_l = '0; cur_r = '0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    wait (kraw >= 4 * FRAMEK + 2);
    @(posedge clk);
    finish_run();
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

endmodule